// File: doc/BRIEF.md
# Disc Table-of-Contents Reply Streamer

This block builds the reply to a read-table-of-contents request for an optical disc that holds one session and one data track. The request carries the total sector count, a flag that picks minute/second/frame (MSF) or plain logical-block (LBA) addressing, a starting-track field and a format code. The block answers three formats: the track table, a fixed session summary and a fixed set of raw subchannel-style point entries. It sends the reply one byte per cycle over a valid/ready stream. Requests that cannot be served raise a one-cycle error pulse and send no bytes.

A 16-bit big-endian length field opens every reply, and the entries that follow decide that length. The block therefore works out the total length from the format code and the starting track when it accepts a request, before the first byte leaves. It holds the request fields while the reply streams. It converts addresses to MSF form on the fly by dividing by constants, and counts the 150-frame pregap into that form.

Top module: `toc_reply_gen`

## Requirements
- R1: After reset `out_valid` and `err_pulse` are 0 and `req_ready` is 1.
- R2: In MSF mode an address field is four bytes: 0x00, then minute, second and frame of t = address + 150. Minute is (t/75)/60 truncated to 8 bits, second is (t/75) mod 60 and frame is t mod 75. Address 0 therefore reads 00 00 02 00.
- R3: Every reply starts with (length − 2) as a big-endian 16-bit value in bytes 0 and 1. Bytes 2 and 3 are both 0x01.
- R4: For format 0 with a starting track of 0 or 1, bytes 4 to 11 form the track entry: 00 14 01 00 followed by the address field of block 0, and the reply is 20 bytes long. With a starting track of 0xAA this entry is left out and the reply is 12 bytes long.
- R5: For format 0 the lead-out entry is always last: 00 16 AA 00 followed by the address field of the sector count. In LBA mode an address field is the 32-bit value, most significant byte first.
- R6: Format 0 with a starting track above 1 that is not 0xAA is rejected with an error.
- R7: Format 1 returns 12 bytes: 00 0A 01 01 and then eight zero bytes.
- R8: Format 2 returns 48 bytes: the 4-byte header and then four 11-byte entries. Each entry is 01 14 00, then a point byte (A0, A1, A2 and 01, in that order), then three zero bytes, then four bytes. The four bytes are 00 01 00 00 for the A0 and A1 entries, the sector-count address field for A2 and the block-0 address field for point 01.
- R9: Format codes 3 to 15 are rejected. A rejected request pulses `err_pulse` high for the one cycle after acceptance and produces no `out_valid`.
- R10: `out_last` is high only on the final byte of a reply. `reply_len` equals the reply's byte count while it streams.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `req_ready` stays low from acceptance until the last byte handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_sectors | input | LBA_W | Total sector count of the disc |
| req_msf | input | 1 | 1: MSF address fields, 0: LBA |
| req_start_trk | input | 8 | Starting-track field |
| req_fmt | input | 4 | Format code |
| err_pulse | output | 1 | One-cycle pulse for a rejected request |
| reply_len | output | 16 | Byte count of the current reply |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |

## Verification
The bench sweeps all sixteen format codes, both address modes and a set of starting tracks. The tracks sit on and around the boundaries 1 and 0xAA. Sector counts are chosen so the MSF conversion crosses frame, second and minute boundaries and overflows the 8-bit minute. A design that forgot the 150-frame pregap, or swapped the divide and modulo, would return wrong address bytes. A design that sized the header from a fixed length would mislabel the 12-byte lead-out-only reply. A design that got the track boundary wrong would stream a reply where an error was due, or reject a valid request. An uneven ready pattern shows whether a byte is skipped or repeated under backpressure.

// File: rtl/toc_pkg.sv
package toc_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } toc_state_e;

   typedef struct packed {
      logic [7:0] ff;
      logic [7:0] ss;
      logic [7:0] mm;
   } msf_t;

   localparam logic [1:0] FMT_TRACKS  = 2'd0;
   localparam logic [1:0] FMT_SESSION = 2'd1;
   localparam logic [1:0] FMT_POINTS  = 2'd2;

   localparam int LEN_TRACKS_FULL = 20;
   localparam int LEN_TRACKS_LO   = 12;
   localparam int LEN_SESSION     = 12;
   localparam int LEN_POINTS      = 48;
   localparam int HDR_BYTES       = 4;
   localparam int TRK_ENT_BYTES   = 8;
   localparam int PNT_ENT_BYTES   = 11;

   localparam logic [7:0] CTL_DATA     = 8'h14;
   localparam logic [7:0] CTL_LEADOUT  = 8'h16;
   localparam logic [7:0] TRK_LEADOUT  = 8'hAA;

endpackage

// File: rtl/toc_msf_conv.sv
module toc_msf_conv
   import toc_pkg::*;
#(
   parameter int LBA_W  = 32,
   parameter int PREGAP = 150,
   parameter int FPS    = 75,
   parameter int SPM    = 60
) (
   input  logic [LBA_W-1:0] lba,
   output msf_t             msf
);
   localparam int SUM_W = LBA_W + 1;

   logic [SUM_W-1:0] abs_frm;
   logic [SUM_W-1:0] secs;

   initial begin : p_param_chk
      if (FPS < 2 || FPS > 255) $error("toc_msf_conv: FPS out of range");
      if (SPM < 2 || SPM > 255) $error("toc_msf_conv: SPM out of range");
   end

   always_comb begin
      abs_frm = SUM_W'(lba) + SUM_W'(PREGAP);
      secs    = abs_frm / SUM_W'(FPS);
      msf.ff  = 8'(abs_frm % SUM_W'(FPS));
      msf.ss  = 8'(secs % SUM_W'(SPM));
      msf.mm  = 8'(secs / SUM_W'(SPM));
   end

endmodule

// File: rtl/toc_addr_field.sv
module toc_addr_field
   import toc_pkg::*;
#(
   parameter int LBA_W = 32
) (
   input  logic [LBA_W-1:0] lba,
   input  msf_t             msf,
   input  logic             msf_mode,
   output logic [3:0][7:0]  fld
);
   logic [31:0]     lba32;
   logic [3:0][7:0] msf_b;

   initial begin : p_param_chk
      if (LBA_W < 8 || LBA_W > 32) $error("toc_addr_field: LBA_W must be 8..32");
   end

   assign lba32 = 32'(lba);
   assign msf_b = {msf.ff, msf.ss, msf.mm, 8'h00};

   for (genvar g = 0; g < 4; g++) begin : g_byte
      assign fld[g] = msf_mode ? msf_b[g] : lba32[8*(3-g) +: 8];
   end

endmodule

// File: rtl/toc_byte_sel.sv
module toc_byte_sel
   import toc_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic [1:0]       fmt,
   input  logic             has_trk,
   input  logic [IDX_W-1:0] idx,
   input  logic [15:0]      hdr_val,
   input  logic [3:0][7:0]  fld_end,
   input  logic [3:0][7:0]  fld_zero,
   output logic [7:0]       byte_o
);
   logic [IDX_W-1:0] pos;
   logic [IDX_W-1:0] ent;
   logic [IDX_W-1:0] sub;
   logic [IDX_W-1:0] sub7;
   logic             lead;

   always_comb begin
      pos    = idx - IDX_W'(HDR_BYTES);
      ent    = '0;
      sub    = '0;
      sub7   = '0;
      lead   = 1'b0;
      byte_o = 8'h00;
      if (idx == IDX_W'(0)) begin
         byte_o = hdr_val[15:8];
      end else if (idx == IDX_W'(1)) begin
         byte_o = hdr_val[7:0];
      end else if (idx < IDX_W'(HDR_BYTES)) begin
         byte_o = 8'h01;
      end else if (fmt == FMT_TRACKS) begin
         ent  = pos / IDX_W'(TRK_ENT_BYTES);
         sub  = pos % IDX_W'(TRK_ENT_BYTES);
         lead = has_trk ? (ent == IDX_W'(1)) : (ent == IDX_W'(0));
         case (sub)
            IDX_W'(1): byte_o = lead ? CTL_LEADOUT : CTL_DATA;
            IDX_W'(2): byte_o = lead ? TRK_LEADOUT : 8'h01;
            IDX_W'(0), IDX_W'(3): byte_o = 8'h00;
            default:   byte_o = lead ? fld_end[sub[1:0]] : fld_zero[sub[1:0]];
         endcase
      end else if (fmt == FMT_POINTS) begin
         ent  = pos / IDX_W'(PNT_ENT_BYTES);
         sub  = pos % IDX_W'(PNT_ENT_BYTES);
         sub7 = sub - IDX_W'(7);
         case (sub)
            IDX_W'(0): byte_o = 8'h01;
            IDX_W'(1): byte_o = CTL_DATA;
            IDX_W'(3): begin
               case (ent)
                  IDX_W'(0): byte_o = 8'hA0;
                  IDX_W'(1): byte_o = 8'hA1;
                  IDX_W'(2): byte_o = 8'hA2;
                  default:   byte_o = 8'h01;
               endcase
            end
            IDX_W'(7), IDX_W'(8), IDX_W'(9), IDX_W'(10): begin
               if (ent == IDX_W'(2))      byte_o = fld_end[sub7[1:0]];
               else if (ent == IDX_W'(3)) byte_o = fld_zero[sub7[1:0]];
               else                       byte_o = (sub == IDX_W'(8)) ? 8'h01 : 8'h00;
            end
            default: byte_o = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/toc_reply_gen.sv
module toc_reply_gen
   import toc_pkg::*;
#(
   parameter int LBA_W  = 32,
   parameter int IDX_W  = 6,
   parameter int PREGAP = 150,
   parameter int FPS    = 75,
   parameter int SPM    = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LBA_W-1:0] req_sectors,
   input  logic             req_msf,
   input  logic [7:0]       req_start_trk,
   input  logic [3:0]       req_fmt,
   output logic             err_pulse,
   output logic [15:0]      reply_len,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_last
);
   localparam int MAX_LEN = LEN_POINTS;

   initial begin : p_param_chk
      if ((1 << IDX_W) <= MAX_LEN) $error("toc_reply_gen: IDX_W too small");
      if (IDX_W > 16) $error("toc_reply_gen: IDX_W too large");
   end

   toc_state_e       state_q;
   logic [LBA_W-1:0] sect_q;
   logic             msf_q;
   logic             trk_q;
   logic [1:0]       fmt_q;
   logic [IDX_W-1:0] len_q;
   logic [IDX_W-1:0] idx_q;
   logic             err_q;

   logic             accept;
   logic             bad_req;
   logic             has_trk_in;
   logic [IDX_W-1:0] len_in;
   logic             fire;

   msf_t             end_msf;
   msf_t             zero_msf;
   logic [3:0][7:0]  fld_end;
   logic [3:0][7:0]  fld_zero;
   logic [15:0]      hdr_val;

   always_comb begin
      has_trk_in = (req_start_trk <= 8'd1);
      bad_req    = (req_fmt > 4'd2) ||
                   ((req_fmt == 4'd0) && !has_trk_in && (req_start_trk != TRK_LEADOUT));
      if (req_fmt == 4'd0)      len_in = has_trk_in ? IDX_W'(LEN_TRACKS_FULL) : IDX_W'(LEN_TRACKS_LO);
      else if (req_fmt == 4'd1) len_in = IDX_W'(LEN_SESSION);
      else                      len_in = IDX_W'(LEN_POINTS);
   end

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign out_valid = (state_q == ST_SEND);
   assign out_last  = out_valid && (idx_q == len_q - IDX_W'(1));
   assign fire      = out_valid && out_ready;
   assign err_pulse = err_q;
   assign reply_len = 16'(len_q);
   assign hdr_val   = 16'(len_q) - 16'd2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sect_q  <= '0;
         msf_q   <= 1'b0;
         trk_q   <= 1'b0;
         fmt_q   <= 2'd0;
         len_q   <= '0;
         idx_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= accept && bad_req;
         case (state_q)
            ST_IDLE: begin
               if (accept && !bad_req) begin
                  sect_q  <= req_sectors;
                  msf_q   <= req_msf;
                  trk_q   <= has_trk_in;
                  fmt_q   <= req_fmt[1:0];
                  len_q   <= len_in;
                  idx_q   <= '0;
                  state_q <= ST_SEND;
               end
            end
            default: begin
               if (fire) begin
                  idx_q <= idx_q + IDX_W'(1);
                  if (out_last) state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   toc_msf_conv #(.LBA_W(LBA_W), .PREGAP(PREGAP), .FPS(FPS), .SPM(SPM)) u_conv_end (
      .lba (sect_q),
      .msf (end_msf)
   );

   toc_msf_conv #(.LBA_W(LBA_W), .PREGAP(PREGAP), .FPS(FPS), .SPM(SPM)) u_conv_zero (
      .lba ('0),
      .msf (zero_msf)
   );

   toc_addr_field #(.LBA_W(LBA_W)) u_fld_end (
      .lba      (sect_q),
      .msf      (end_msf),
      .msf_mode (msf_q),
      .fld      (fld_end)
   );

   toc_addr_field #(.LBA_W(LBA_W)) u_fld_zero (
      .lba      ('0),
      .msf      (zero_msf),
      .msf_mode (msf_q),
      .fld      (fld_zero)
   );

   toc_byte_sel #(.IDX_W(IDX_W)) u_sel (
      .fmt      (fmt_q),
      .has_trk  (trk_q),
      .idx      (idx_q),
      .hdr_val  (hdr_val),
      .fld_end  (fld_end),
      .fld_zero (fld_zero),
      .byte_o   (out_data)
   );

endmodule

// File: rtl/toc_reply_chk.sv
module toc_reply_chk #(
   parameter int FPS = 75,
   parameter int SPM = 60
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_ready,
   input logic        err_pulse,
   input logic [15:0] reply_len,
   input logic        out_valid,
   input logic        out_ready,
   input logic [7:0]  out_data,
   input logic        out_last,
   input logic [7:0]  msf_sec,
   input logic [7:0]  msf_frm
);

   AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R11

   AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !req_ready); // R11

   AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !out_valid); // R9

   AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid && req_ready); // R10

   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (reply_len == 16'd12 || reply_len == 16'd20 || reply_len == 16'd48)); // R10

   AST_MSF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(msf_sec) < SPM) && (32'(msf_frm) < FPS)); // R2

endmodule

bind toc_reply_gen toc_reply_chk #(.FPS(FPS), .SPM(SPM)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .err_pulse (err_pulse),
   .reply_len (reply_len),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last),
   .msf_sec   (end_msf.ss),
   .msf_frm   (end_msf.ff)
);

// File: tb/toc_reply_gen_bench.sv
module toc_reply_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_sectors = '0;
   logic        req_msf = 1'b0;
   logic [7:0]  req_start_trk = '0;
   logic [3:0]  req_fmt = '0;
   logic        err_pulse;
   logic [15:0] reply_len;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        out_last;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int bp     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   toc_reply_gen u_toc_reply_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_sectors   (req_sectors),
      .req_msf       (req_msf),
      .req_start_trk (req_start_trk),
      .req_fmt       (req_fmt),
      .err_pulse     (err_pulse),
      .reply_len     (reply_len),
      .out_valid     (out_valid),
      .out_ready     (out_ready),
      .out_data      (out_data),
      .out_last      (out_last)
   );

   task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int exp_len(input int f, input int st);
      if (f == 0) return (st <= 1) ? 20 : 12;
      if (f == 1) return 12;
      return 48;
   endfunction

   function automatic logic [7:0] addr_byte(input longint v, input bit m, input int k);
      longint t;
      t = v + 150;
      if (!m) return 8'((v >> (8 * (3 - k))) & 255);
      case (k)
         0: return 8'h00;
         1: return 8'(((t / 75) / 60) & 255);
         2: return 8'((t / 75) % 60);
         default: return 8'(t % 75);
      endcase
   endfunction

   function automatic logic [7:0] exp_byte(input int f, input bit m, input int st,
                                           input longint cnt, input int n);
      int hdr, p, e, j;
      bit lead;
      hdr = exp_len(f, st) - 2;
      if (n == 0) return 8'(hdr >> 8);
      if (n == 1) return 8'(hdr & 255);
      if (n < 4) return 8'h01;
      p = n - 4;
      if (f == 1) return 8'h00;
      if (f == 0) begin
         e = p / 8; j = p % 8;
         lead = (st <= 1) ? (e == 1) : (e == 0);
         if (j == 0 || j == 3) return 8'h00;
         if (j == 1) return lead ? 8'h16 : 8'h14;
         if (j == 2) return lead ? 8'hAA : 8'h01;
         return addr_byte(lead ? cnt : 0, m, j - 4);
      end
      e = p / 11; j = p % 11;
      if (j == 0) return 8'h01;
      if (j == 1) return 8'h14;
      if (j == 3) return (e == 0) ? 8'hA0 : (e == 1) ? 8'hA1 : (e == 2) ? 8'hA2 : 8'h01;
      if (j < 7) return 8'h00;
      if (e == 2) return addr_byte(cnt, m, j - 7);
      if (e == 3) return addr_byte(0, m, j - 7);
      return (j == 8) ? 8'h01 : 8'h00;
   endfunction

   function automatic string byte_tag(input int f, input bit m, input int st, input int n);
      if (f == 1) return "R7";
      if (f == 2) return "R8";
      if (n < 4) return "R3";
      if (m && ((n - 4) % 8) >= 4) return "R2";
      if (st <= 1 && n < 12) return "R4";
      return "R5";
   endfunction

   task automatic run_req(input int f, input bit m, input int st, input longint cnt);
      int len, n, guard;
      bit bad, rdy;
      bad = (f > 2) || (f == 0 && st > 1 && st != 8'hAA);
      len = exp_len(f, st);
      @(negedge clk);
      chk(req_ready == 1'b1, "R11 idle ready", longint'(req_ready), 1);
      req_valid     = 1'b1;
      req_fmt       = 4'(f);
      req_msf       = m;
      req_start_trk = 8'(st);
      req_sectors   = 32'(cnt);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (bad) begin
         chk(err_pulse == 1'b1 && out_valid == 1'b0, (f > 2) ? "R9 reject" : "R6 reject",
             longint'({err_pulse, out_valid}), 2);
         @(negedge clk);
         chk(out_valid == 1'b0 && req_ready == 1'b1, "R9 no bytes",
             longint'({out_valid, req_ready}), 1);
         return;
      end
      chk(err_pulse == 1'b0, "R9 no error on valid request", longint'(err_pulse), 0);
      n = 0;
      guard = 0;
      while (n < len && guard < 400) begin
         guard++;
         bp++;
         rdy = (bp % 3) != 0;
         out_ready = rdy;
         if (!out_valid) begin
            chk(1'b0, "R10 stream stalled", 0, 1);
            break;
         end
         chk(out_data == exp_byte(f, m, st, cnt, n), byte_tag(f, m, st, n),
             longint'(out_data), longint'(exp_byte(f, m, st, cnt, n)));
         chk(out_last == (n == len - 1) && reply_len == 16'(len), "R10 last/length",
             longint'({out_last, reply_len}), longint'({(n == len - 1), 16'(len)}));
         chk(req_ready == 1'b0, "R11 busy", longint'(req_ready), 0);
         @(posedge clk);
         if (rdy) n++;
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(out_valid == 1'b0 && req_ready == 1'b1, "R10 end of reply",
          longint'({out_valid, req_ready}), 1);
   endtask

   initial begin : p_watchdog
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : p_main
      int tracks [6];
      longint counts [8];
      tracks = '{0, 1, 2, 8'hAA, 8'hAB, 8'hFF};
      counts = '{0, 1, 74, 4349, 4350, 333000, 64'h00ABCDEF, 64'hFFFFFF00};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0 && err_pulse == 1'b0 && req_ready == 1'b1, "R1 reset state",
          longint'({out_valid, err_pulse, req_ready}), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && req_ready == 1'b1, "R1 after release",
          longint'({out_valid, req_ready}), 1);
      for (int f = 0; f < 16; f++)
         for (int m = 0; m < 2; m++)
            for (int s = 0; s < 6; s++)
               for (int c = 0; c < 8; c++)
                  run_req(f, m[0], tracks[s], counts[c]);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule